// File: doc/BRIEF.md
# Pipeline Hazard Steering Unit

This block is the hazard control for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Every cycle it looks at what sits in the decode and execute pipeline registers and at the branch-resolution signal. From these it decides whether fetch and decode advance, repeat or are discarded. All of its outputs are combinational from its inputs, so the surrounding pipeline registers act on them at the next clock edge.

There are two conditions to handle. The first is a load-use dependency: the instruction in execute is a memory read, and the instruction in decode names that load's destination as one of its source registers. In that case the program counter and the fetch/decode register hold for one cycle. The control fields written into the decode/execute register are also zeroed, so a bubble enters execute. After that single cycle the loaded value reaches the waiting instruction through the writeback forwarding path. The second condition is a taken branch resolved late. Both younger instructions are discarded: the fetch/decode register is cleared to the all-zero nop, the decode/execute control fields are cleared, and the program counter takes the branch target. A taken branch outranks a load-use condition in the same cycle. While the synchronous reset is high, the block asks for both stages to be cleared, so every pipeline register comes out of reset holding a nop.

There is no data stream through this block. Every pin is a plain level-sensitive control signal with no valid/ready handshake and no back-pressure.

Top module: `hazard_steer`

## Requirements
- R1: When `ex_is_load` is 1, `ex_dst` is nonzero, and `ex_dst` equals any source slot of `dec_srcs` (slot k occupies bits [k*REG_AW +: REG_AW]; slot 0 is the first source and slot 1 is the second), the block stalls, provided `rst` and `br_taken` are both 0.
- R2: A load whose destination is register 0 never causes a stall, even if a source slot also names register 0.
- R3: When `ex_is_load` is 0 there is no stall, whatever the register numbers.
- R4: In a stall, `pc_we`=0, `ifid_we`=0 and `idex_bubble`=1, while `flush_dec`, `flush_ex` and `pc_take_tgt` stay 0.
- R5: When `br_taken`=1 and `rst`=0, the outputs are `flush_dec`=1, `flush_ex`=1, `idex_bubble`=1, `pc_take_tgt`=1, `pc_we`=1 and `ifid_we`=1.
- R6: A taken branch outranks a load-use condition in the same cycle: the outputs are exactly those of R5.
- R7: With no reset, no branch and no load-use hit (including a load with no matching source), `pc_we`=1, `ifid_we`=1 and all other outputs are 0.
- R8: While `rst`=1, the outputs are `flush_dec`=1, `flush_ex`=1, `idex_bubble`=1, `ifid_we`=1, `pc_we`=0 and `pc_take_tgt`=0, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only by the embedded property checks |
| rst | input | 1 | Synchronous reset of the pipeline, active high |
| ex_is_load | input | 1 | Instruction in the decode/execute register reads memory |
| ex_dst | input | REG_AW | Destination register of that instruction |
| dec_srcs | input | NUM_SRC*REG_AW | Source register numbers of the instruction in the fetch/decode register |
| br_taken | input | 1 | Branch resolved taken this cycle |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| idex_bubble | output | 1 | Zero the control fields loaded into decode/execute |
| flush_dec | output | 1 | Clear the fetch/decode register to the nop encoding |
| flush_ex | output | 1 | Clear the decode/execute stage controls |
| pc_take_tgt | output | 1 | Program counter takes the branch target |

## Verification
The bench uses the default parameters: 5-bit register numbers and two source slots. With these values a match can be placed in either slot, a match can be made on the highest register number (31), and register 0 can name the destination and both sources at once. The table applies the stall, no-stall, branch-over-stall and reset cases one vector at a time. Directed steps then follow a stall with the bubble that it inserts, to show that the condition clears after one cycle.

// File: rtl/hazard_steer_pkg.sv
package hazard_steer_pkg;

  typedef struct packed {
    logic pc_we;
    logic ifid_we;
    logic idex_bubble;
    logic flush_dec;
    logic flush_ex;
    logic pc_take_tgt;
  } steer_t;

  localparam steer_t STEER_RUN   = '{pc_we: 1'b1, ifid_we: 1'b1, idex_bubble: 1'b0,
                                     flush_dec: 1'b0, flush_ex: 1'b0, pc_take_tgt: 1'b0};
  localparam steer_t STEER_HOLD  = '{pc_we: 1'b0, ifid_we: 1'b0, idex_bubble: 1'b1,
                                     flush_dec: 1'b0, flush_ex: 1'b0, pc_take_tgt: 1'b0};
  localparam steer_t STEER_SQUASH = '{pc_we: 1'b1, ifid_we: 1'b1, idex_bubble: 1'b1,
                                      flush_dec: 1'b1, flush_ex: 1'b1, pc_take_tgt: 1'b1};
  localparam steer_t STEER_INIT  = '{pc_we: 1'b0, ifid_we: 1'b1, idex_bubble: 1'b1,
                                     flush_dec: 1'b1, flush_ex: 1'b1, pc_take_tgt: 1'b0};

endpackage

// File: rtl/hazard_src_match.sv
module hazard_src_match #(
  parameter int REG_AW  = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [REG_AW-1:0]         dst,
  input  logic [NUM_SRC*REG_AW-1:0] srcs,
  output logic                      any_hit
);
  logic [NUM_SRC-1:0] slot_hit;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_slot
    assign slot_hit[k] = (srcs[k*REG_AW +: REG_AW] == dst);
  end

  assign any_hit = |slot_hit;
endmodule

// File: rtl/hazard_load_use.sv
module hazard_load_use #(
  parameter int REG_AW  = 5,
  parameter int NUM_SRC = 2
) (
  input  logic                      ex_is_load,
  input  logic [REG_AW-1:0]         ex_dst,
  input  logic [NUM_SRC*REG_AW-1:0] dec_srcs,
  output logic                      stall_req
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic src_hit;
  logic dst_live;

  hazard_src_match #(.REG_AW(REG_AW), .NUM_SRC(NUM_SRC)) u_match (
    .dst     (ex_dst),
    .srcs    (dec_srcs),
    .any_hit (src_hit)
  );

  assign dst_live  = (ex_dst != ZERO_REG);
  assign stall_req = ex_is_load && dst_live && src_hit;
endmodule

// File: rtl/hazard_arbiter.sv
module hazard_arbiter
  import hazard_steer_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   flush_req,
  input  logic   stall_req,
  output steer_t ctl
);
  always_comb begin
    if (rst)            ctl = STEER_INIT;
    else if (flush_req) ctl = STEER_SQUASH;
    else if (stall_req) ctl = STEER_HOLD;
    else                ctl = STEER_RUN;
  end

  // R4
  hold_freezes_chk: assert property (@(posedge clk) disable iff (rst)
    (stall_req && !flush_req) |-> (!ctl.pc_we && !ctl.ifid_we && ctl.idex_bubble
                                   && !ctl.flush_dec && !ctl.flush_ex));

  // R6
  flush_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (flush_req && stall_req) |-> (ctl.pc_we && ctl.pc_take_tgt && ctl.flush_dec));

  // R5
  tgt_needs_flush_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.pc_take_tgt |-> (ctl.flush_dec && ctl.flush_ex && ctl.idex_bubble));
endmodule

// File: rtl/hazard_steer.sv
module hazard_steer
  import hazard_steer_pkg::*;
#(
  parameter int REG_AW  = 5,
  parameter int NUM_SRC = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ex_is_load,
  input  logic [REG_AW-1:0]         ex_dst,
  input  logic [NUM_SRC*REG_AW-1:0] dec_srcs,
  input  logic                      br_taken,
  output logic                      pc_we,
  output logic                      ifid_we,
  output logic                      idex_bubble,
  output logic                      flush_dec,
  output logic                      flush_ex,
  output logic                      pc_take_tgt
);
  logic   stall_req;
  steer_t ctl;

  hazard_load_use #(.REG_AW(REG_AW), .NUM_SRC(NUM_SRC)) u_detect (
    .ex_is_load (ex_is_load),
    .ex_dst     (ex_dst),
    .dec_srcs   (dec_srcs),
    .stall_req  (stall_req)
  );

  hazard_arbiter u_arb (
    .clk       (clk),
    .rst       (rst),
    .flush_req (br_taken),
    .stall_req (stall_req),
    .ctl       (ctl)
  );

  assign pc_we       = ctl.pc_we;
  assign ifid_we     = ctl.ifid_we;
  assign idex_bubble = ctl.idex_bubble;
  assign flush_dec   = ctl.flush_dec;
  assign flush_ex    = ctl.flush_ex;
  assign pc_take_tgt = ctl.pc_take_tgt;

  // R2
  zero_dst_runs_chk: assert property (@(posedge clk) disable iff (rst)
    (!br_taken && ex_dst == '0) |-> (pc_we && ifid_we));

  // R3
  no_load_runs_chk: assert property (@(posedge clk) disable iff (rst)
    (!br_taken && !ex_is_load) |-> (pc_we && ifid_we && !idex_bubble));

  // R5
  branch_clears_chk: assert property (@(posedge clk) disable iff (rst)
    br_taken |-> (flush_dec && flush_ex && pc_take_tgt && pc_we));

  // R8
  always_comb begin
    if (rst) begin
      reset_nops_chk: assert (flush_dec && flush_ex && idex_bubble && !pc_we && !pc_take_tgt);
    end
  end
endmodule

// File: tb/hazard_steer_test.sv
module hazard_steer_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;
  localparam int NS = 2;
  localparam int NVEC = 12;

  logic clk = 1'b0;
  logic rst;
  logic ex_is_load;
  logic [AW-1:0] ex_dst;
  logic [NS*AW-1:0] dec_srcs;
  logic br_taken;
  logic pc_we, ifid_we, idex_bubble, flush_dec, flush_ex, pc_take_tgt;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hazard_steer #(.REG_AW(AW), .NUM_SRC(NS)) uut (
    .clk(clk), .rst(rst), .ex_is_load(ex_is_load), .ex_dst(ex_dst),
    .dec_srcs(dec_srcs), .br_taken(br_taken), .pc_we(pc_we), .ifid_we(ifid_we),
    .idex_bubble(idex_bubble), .flush_dec(flush_dec), .flush_ex(flush_ex),
    .pc_take_tgt(pc_take_tgt)
  );

  // vector: rst, br, load, dst[5], src0[5], src1[5], expected {pc_we,ifid_we,bubble,fdec,fex,tgt}[6], req[4]
  localparam logic [27:0] TBL [NVEC] = '{
    {1'b0, 1'b0, 1'b0, 5'd4,  5'd4,  5'd4,  6'b110000, 4'd3},  // R3 no load
    {1'b0, 1'b0, 1'b1, 5'd4,  5'd4,  5'd7,  6'b001000, 4'd1},  // R1 slot 0
    {1'b0, 1'b0, 1'b1, 5'd4,  5'd7,  5'd4,  6'b001000, 4'd1},  // R1 slot 1
    {1'b0, 1'b0, 1'b1, 5'd0,  5'd0,  5'd0,  6'b110000, 4'd2},  // R2 zero reg
    {1'b0, 1'b0, 1'b1, 5'd5,  5'd4,  5'd6,  6'b110000, 4'd7},  // R7 load, no match
    {1'b0, 1'b1, 1'b0, 5'd4,  5'd9,  5'd9,  6'b111111, 4'd5},  // R5 branch
    {1'b0, 1'b1, 1'b1, 5'd4,  5'd4,  5'd4,  6'b111111, 4'd6},  // R6 branch over stall
    {1'b0, 1'b0, 1'b1, 5'd31, 5'd31, 5'd0,  6'b001000, 4'd1},  // R1 top register
    {1'b1, 1'b1, 1'b1, 5'd4,  5'd4,  5'd4,  6'b011110, 4'd8},  // R8 reset over all
    {1'b1, 1'b0, 1'b0, 5'd0,  5'd0,  5'd0,  6'b011110, 4'd8},  // R8 reset idle
    {1'b0, 1'b0, 1'b0, 5'd3,  5'd3,  5'd3,  6'b110000, 4'd3},  // R3 match, no load
    {1'b0, 1'b0, 1'b1, 5'd1,  5'd2,  5'd1,  6'b001000, 4'd4}   // R4 stall outputs
  };

  function automatic logic [5:0] outs();
    return {pc_we, ifid_we, idex_bubble, flush_dec, flush_ex, pc_take_tgt};
  endfunction

  task automatic check(input logic [5:0] exp, input int req, input string what);
    checks++;
    if (outs() !== exp) begin
      errors++;
      $display("FAIL R%0d %s: got %b expected %b", req, what, outs(), exp);
    end
  endtask

  task automatic apply(input logic r, input logic b, input logic ld,
                       input logic [AW-1:0] d, input logic [AW-1:0] s0,
                       input logic [AW-1:0] s1);
    @(negedge clk);
    rst = r; br_taken = b; ex_is_load = ld; ex_dst = d;
    dec_srcs = {s1, s0};
    #1;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst = 1'b1; br_taken = 1'b0; ex_is_load = 1'b0; ex_dst = '0; dec_srcs = '0;
    apply(1'b1, 1'b0, 1'b0, 5'd0, 5'd0, 5'd0);
    check(6'b011110, 8, "reset state R8");
    apply(1'b1, 1'b0, 1'b0, 5'd0, 5'd0, 5'd0);
    check(6'b011110, 8, "reset held R8");

    for (int i = 0; i < NVEC; i++) begin
      logic [27:0] v;
      v = TBL[i];
      apply(v[27], v[26], v[25], v[24:20], v[19:15], v[14:10]);
      check(v[9:4], int'(v[3:0]), $sformatf("table vector %0d", i));
    end

    // R4: stall then bubble in execute; dependent instruction now proceeds
    apply(1'b0, 1'b0, 1'b1, 5'd8, 5'd8, 5'd2);
    check(6'b001000, 4, "load-use stall R4");
    apply(1'b0, 1'b0, 1'b0, 5'd0, 5'd8, 5'd2);
    check(6'b110000, 3, "bubble after stall R3");

    // R6: branch arrives while a stall condition persists across two cycles
    apply(1'b0, 1'b0, 1'b1, 5'd12, 5'd1, 5'd12);
    check(6'b001000, 1, "stall before branch R1");
    apply(1'b0, 1'b1, 1'b1, 5'd12, 5'd1, 5'd12);
    check(6'b111111, 6, "branch overrides stall R6");

    // R2: zero destination matching only in slot 1
    apply(1'b0, 1'b0, 1'b1, 5'd0, 5'd5, 5'd0);
    check(6'b110000, 2, "zero destination R2");

    // R7: idle after traffic
    apply(1'b0, 1'b0, 1'b1, 5'd30, 5'd29, 5'd28);
    check(6'b110000, 7, "load without match R7");

    // R8: reset asserted mid-run
    apply(1'b1, 1'b0, 1'b1, 5'd3, 5'd3, 5'd3);
    check(6'b011110, 8, "reset mid-run R8");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule